// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a timer array running in single-shot output compare operation. Software writes a match value through a register write port. The value goes into a staging register and is passed on at once to the active compare register. The read port always returns the active compare register. While the channel's 7-bit mode code selects compare operation, the channel watches a counter bus. It takes that bus from either an internal or an external time base, picked by a two-bit select field. When the bus equals the active compare value, the channel acts on its output flip-flop and sets a sticky flag.

Two settings shape the output action. The action-select bit chooses between toggling the flip-flop and loading it with the polarity bit. A software force input runs the same output action without touching the flag. When the channel enters compare operation from a general-purpose I/O mode code, the output is preset to the inverse of the polarity bit. This gives the first real match a defined edge to produce.

Top module: `ocmp_channel`

## Requirements
- R1: While rst_n is low, out_pin is 0, flag is 0 and rd_data is 0.
- R2: A cycle with wr_en high loads wr_data into the staging register and, through it, into the active compare register at the same clock edge. From the next cycle on, rd_data shows the active compare value.
- R3: The channel acts only when mode_in equals 7'b0000011. With any other code, out_pin holds its value, and neither matches nor force_match change out_pin or flag.
- R4: In compare mode, when the selected counter value equals the active compare value, flag is 1 after the next clock edge.
- R5: On a match, act_sel=1 inverts out_pin at the next edge, and act_sel=0 loads out_pin with pol at the next edge.
- R6: force_match high in compare mode performs the R5 action at the next edge and leaves flag unchanged. A force and a match in the same cycle give a single action.
- R7: On the first cycle with mode_in=7'b0000011 after a cycle whose code was 7'b0000000 or 7'b0000001, out_pin becomes the inverse of pol at the next edge. This preset wins over any match or force in that cycle. After reset, the previous code counts as 7'b0000000.
- R8: bus_sel=2'b11 selects cnt_int as the counter bus, and every other bus_sel value selects cnt_ext.
- R9: A match is an event only in a cycle where equality holds and did not hold in compare mode in the previous cycle. A counter that rests on the match value acts once.
- R10: flag stays 1 until a cycle with flag_clr high clears it. If flag_clr and a match event fall in the same cycle, flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the match value |
| wr_data | input | CNT_W | Match value to write |
| rd_data | output | CNT_W | Active compare register |
| mode_in | input | 7 | Channel mode code |
| pol | input | 1 | Polarity bit |
| act_sel | input | 1 | 1 toggles on match, 0 loads polarity |
| force_match | input | 1 | Software forced match |
| bus_sel | input | 2 | Counter bus select |
| cnt_int | input | CNT_W | Internal counter bus |
| cnt_ext | input | CNT_W | External counter bus |
| flag_clr | input | 1 | Clears the sticky flag |
| out_pin | output | 1 | Output flip-flop |
| flag | output | 1 | Sticky match flag |

## Verification
Directed sequences cover the cases below. Loading polarity and toggling are both tried, so the two R5 actions are told apart. A counter that rests on the match value separates edge-based detection from level-based detection. A force with no match separates the output path from the flag path. A clear that lands in the same cycle as a match exposes which of the two the flag update favours. Random traffic then mixes bus selections, mode codes (including GPIO codes), rewrites of the compare value and counter values placed near the compare value. This tells apart the internal and external bus paths and finds any stale compare value used after a rewrite.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   localparam int MODE_W = 7;
   typedef logic [MODE_W-1:0] mode_t;
   localparam mode_t MODE_OCMP  = 7'b0000011;
   localparam int    NUM_GPIO   = 2;
   localparam mode_t GPIO_CODES [NUM_GPIO] = '{7'b0000000, 7'b0000001};
   typedef enum logic {ACT_LOAD = 1'b0, ACT_TOGGLE = 1'b1} act_e;
endpackage

// File: rtl/ocmp_bus_mux.sv
module ocmp_bus_mux #(
   parameter int          CNT_W    = 24,
   parameter int          SEL_W    = 2,
   parameter logic [SEL_W-1:0] INT_CODE = '1
) (
   input  logic [SEL_W-1:0] bus_sel,
   input  logic [CNT_W-1:0] cnt_int,
   input  logic [CNT_W-1:0] cnt_ext,
   output logic [CNT_W-1:0] sel_cnt
);
   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("ocmp_bus_mux: SEL_W must be at least 1");
      end
      if (SEL_W == 1) begin : g_bit
         assign sel_cnt = (bus_sel[0] == INT_CODE[0]) ? cnt_int : cnt_ext;
      end else begin : g_code
         assign sel_cnt = (bus_sel == INT_CODE) ? cnt_int : cnt_ext;
      end
   endgenerate
endmodule

// File: rtl/ocmp_match_reg.sv
module ocmp_match_reg #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] active_q
);
   logic [CNT_W-1:0] stage_q;
   logic [CNT_W-1:0] stage_d;

   assign stage_d = wr_en ? wr_data : stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         active_q <= '0;
      end else begin
         stage_q  <= stage_d;
         active_q <= stage_d;
      end
   end
endmodule

// File: rtl/ocmp_match_det.sv
module ocmp_match_det #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_mode,
   input  logic             entry,
   input  logic [CNT_W-1:0] sel_cnt,
   input  logic [CNT_W-1:0] active,
   output logic             match_evt
);
   logic eq_now;
   logic eq_q;

   assign eq_now    = in_mode && (sel_cnt == active);
   assign match_evt = eq_now && !eq_q && !entry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq_now;
   end
endmodule

// File: rtl/ocmp_out_ctl.sv
module ocmp_out_ctl
   import ocmp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_mode,
   input  logic entry,
   input  logic match_evt,
   input  logic force_match,
   input  logic act_sel,
   input  logic pol,
   input  logic flag_clr,
   output logic out_pin,
   output logic flag
);
   logic do_act;
   logic out_d;

   assign do_act = in_mode && !entry && (match_evt || force_match);

   always_comb begin
      out_d = out_pin;
      if (entry)       out_d = ~pol;
      else if (do_act) out_d = (act_e'(act_sel) == ACT_TOGGLE) ? ~out_pin : pol;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pin <= 1'b0;
         flag    <= 1'b0;
      end else begin
         out_pin <= out_d;
         flag    <= match_evt | (flag & ~flag_clr);
      end
   end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic [6:0]       mode_in,
   input  logic             pol,
   input  logic             act_sel,
   input  logic             force_match,
   input  logic [SEL_W-1:0] bus_sel,
   input  logic [CNT_W-1:0] cnt_int,
   input  logic [CNT_W-1:0] cnt_ext,
   input  logic             flag_clr,
   output logic             out_pin,
   output logic             flag
);
   localparam logic [SEL_W-1:0] INT_CODE = {SEL_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ocmp_channel: CNT_W must be at least 2");
      end
   endgenerate

   mode_t            mode_q;
   logic             in_mode;
   logic             prev_gpio;
   logic             entry;
   logic             match_evt;
   logic [CNT_W-1:0] sel_cnt;
   logic [NUM_GPIO-1:0] gpio_hit;

   generate
      for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
         assign gpio_hit[g] = (mode_q == GPIO_CODES[g]);
      end
   endgenerate

   assign in_mode   = (mode_in == MODE_OCMP);
   assign prev_gpio = |gpio_hit;
   assign entry     = in_mode && prev_gpio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= GPIO_CODES[0];
      else        mode_q <= mode_in;
   end

   ocmp_bus_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W), .INT_CODE(INT_CODE)) u_mux (
      .bus_sel (bus_sel),
      .cnt_int (cnt_int),
      .cnt_ext (cnt_ext),
      .sel_cnt (sel_cnt)
   );

   ocmp_match_reg #(.CNT_W(CNT_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .active_q (rd_data)
   );

   ocmp_match_det #(.CNT_W(CNT_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_mode   (in_mode),
      .entry     (entry),
      .sel_cnt   (sel_cnt),
      .active    (rd_data),
      .match_evt (match_evt)
   );

   ocmp_out_ctl u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_mode     (in_mode),
      .entry       (entry),
      .match_evt   (match_evt),
      .force_match (force_match),
      .act_sel     (act_sel),
      .pol         (pol),
      .flag_clr    (flag_clr),
      .out_pin     (out_pin),
      .flag        (flag)
   );
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] rd_data,
   input logic [6:0]       mode_in,
   input logic             pol,
   input logic             act_sel,
   input logic             flag_clr,
   input logic             out_pin,
   input logic             flag,
   input logic [CNT_W-1:0] sel_cnt,
   input logic             prev_gpio,
   input logic             match_evt
);
   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data)); // R2
   AST_HOLD_OUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_in != 7'b0000011) |=> $stable(out_pin)); // R3
   AST_NO_FLAG_NO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && sel_cnt != rd_data) |=> !flag); // R6
   AST_LOAD_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && !act_sel) |=> out_pin == $past(pol)); // R5
   AST_ENTRY_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_in == 7'b0000011 && prev_gpio) |=> out_pin == !$past(pol)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag); // R10
   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag); // R4
endmodule

bind ocmp_channel ocmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .mode_in   (mode_in),
   .pol       (pol),
   .act_sel   (act_sel),
   .flag_clr  (flag_clr),
   .out_pin   (out_pin),
   .flag      (flag),
   .sel_cnt   (sel_cnt),
   .prev_gpio (prev_gpio),
   .match_evt (match_evt)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb_top;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data;
   logic [6:0]    mode_in = 7'd0;
   logic          pol = 1'b0;
   logic          act_sel = 1'b0;
   logic          force_match = 1'b0;
   logic [1:0]    bus_sel = 2'b00;
   logic [CW-1:0] cnt_int = '0;
   logic [CW-1:0] cnt_ext = '0;
   logic          flag_clr = 1'b0;
   logic          out_pin;
   logic          flag;

   int total = 0;
   int bad   = 0;

   // reference state
   logic [CW-1:0] m_act = '0;
   logic          m_out = 1'b0;
   logic          m_flag = 1'b0;
   logic          m_eqq = 1'b0;
   logic [6:0]    m_modeq = 7'd0;

   always #2.5 clk = ~clk;

   ocmp_channel #(.CNT_W(CW), .SEL_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .mode_in(mode_in), .pol(pol), .act_sel(act_sel), .force_match(force_match),
      .bus_sel(bus_sel), .cnt_int(cnt_int), .cnt_ext(cnt_ext), .flag_clr(flag_clr),
      .out_pin(out_pin), .flag(flag)
   );

   function automatic logic [CW-1:0] pick_cnt(input logic [1:0] sel,
                                              input logic [CW-1:0] ci,
                                              input logic [CW-1:0] ce);
      return (sel == 2'b11) ? ci : ce;   // R8
   endfunction

   task automatic check(input string req, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clock: predict from inputs now, advance, compare at negedge
   task automatic step(input string req);
      logic          in_mode, eq, entry, evt, doact;
      logic [CW-1:0] c;
      in_mode = (mode_in == 7'b0000011);
      c       = pick_cnt(bus_sel, cnt_int, cnt_ext);
      eq      = in_mode && (c == m_act);
      entry   = in_mode && (m_modeq == 7'd0 || m_modeq == 7'd1);
      evt     = eq && !m_eqq && !entry;
      doact   = in_mode && !entry && (evt || force_match);
      if (entry)      m_out = ~pol;
      else if (doact) m_out = act_sel ? ~m_out : pol;
      m_flag  = evt | (m_flag & ~flag_clr);
      if (wr_en) m_act = wr_data;
      m_eqq   = eq;
      m_modeq = mode_in;
      @(posedge clk);
      @(negedge clk);
      check(req, "out_pin", {{(CW-1){1'b0}}, out_pin}, {{(CW-1){1'b0}}, m_out});
      check(req, "flag",    {{(CW-1){1'b0}}, flag},    {{(CW-1){1'b0}}, m_flag});
      check(req, "rd_data", rd_data, m_act);
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; force_match = 1'b0; flag_clr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'h1234_5678;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1", "out_pin reset", {{(CW-1){1'b0}}, out_pin}, '0);
      check("R1", "flag reset",    {{(CW-1){1'b0}}, flag}, '0);
      check("R1", "rd_data reset", rd_data, '0);
      rst_n = 1'b1;

      // R2: write match value while in GPIO mode
      mode_in = 7'd1; bus_sel = 2'b11; cnt_int = 16'h0100;
      wr_en = 1'b1; wr_data = 16'h0200; step("R2");
      idle_inputs(); step("R2");
      // R3: match value present but not in compare mode
      cnt_int = 16'h0200; step("R3");
      force_match = 1'b1; step("R3"); idle_inputs();
      // R7: enter compare from GPIO with pol=1 -> out 0, even with equality
      pol = 1'b1; act_sel = 1'b0; mode_in = 7'b0000011; step("R7");
      cnt_int = 16'h0201; step("R7");
      // R4/R5 load polarity on match
      cnt_int = 16'h0200; step("R4 R5");
      // R9: resting on the match value
      flag_clr = 1'b1; step("R9"); flag_clr = 1'b0;
      step("R9"); step("R9");
      // R5 toggle mode
      act_sel = 1'b1; cnt_int = 16'h0300; step("R5");
      cnt_int = 16'h0200; step("R5");
      // R6 force with no match, flag cleared first
      flag_clr = 1'b1; cnt_int = 16'h0011; step("R10"); flag_clr = 1'b0;
      force_match = 1'b1; step("R6"); force_match = 1'b0; step("R6");
      // R6 force + match in one cycle: single toggle
      cnt_int = 16'h0200; force_match = 1'b1; step("R6"); force_match = 1'b0;
      // R10 clear and match same cycle
      cnt_int = 16'h0300; step("R10");
      cnt_int = 16'h0200; flag_clr = 1'b1; step("R10"); flag_clr = 1'b0;
      // R8 external bus: internal equal but external selects
      bus_sel = 2'b01; cnt_ext = 16'h0050; cnt_int = 16'h0300; step("R8");
      cnt_int = 16'h0200; step("R8");
      cnt_ext = 16'h0200; step("R8");
      // R2 rewrite while running, new value governs
      wr_en = 1'b1; wr_data = 16'h0077; step("R2"); wr_en = 1'b0;
      cnt_ext = 16'h0077; step("R2");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r;
         r = 4'($urandom_range(0, 15));
         mode_in     = (r == 0) ? 7'd0 : (r == 1) ? 7'd1 : (r == 2) ? 7'd5 : 7'b0000011;
         pol         = 1'($urandom);
         act_sel     = 1'($urandom);
         force_match = ($urandom_range(0, 9) == 0);
         flag_clr    = ($urandom_range(0, 5) == 0);
         bus_sel     = 2'($urandom);
         wr_en       = ($urandom_range(0, 15) == 0);
         wr_data     = CW'($urandom_range(0, 7));
         cnt_int     = ($urandom_range(0, 2) == 0) ? m_act : CW'($urandom_range(0, 7));
         cnt_ext     = ($urandom_range(0, 2) == 0) ? m_act : CW'($urandom_range(0, 7));
         step("R11 random R3 R4 R5 R6 R7 R8 R9 R10");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule